// File: doc/BRIEF.md
# Housekeeping SPI Configuration Slave

This block is a serial slave on a dedicated set of SPI pins. It holds the configuration bits that must stay under external control, apart from the processor: enables for the crystal oscillator, the core regulator, the bandgap and the PLL; the PLL divider, select and trim fields; and a general configuration byte. It also returns fixed manufacturer, product and mask-revision codes. Every stored field leaves the block as a plain output wire. The processor reads these wires through its own bus decode and cannot write them.

The SPI pins are sampled in the core clock domain through two-flop synchronisers. Each frame opens with a command byte. The top two bits of that byte choose between a write, a read and pass-through. The low six bits give a start address, or a tap index in the case of pass-through. During pass-through the serial data output carries one internal signal chosen from a small tap bus, with no register in the path. This lasts until chip select goes high again. One control register drives an interrupt line and a reset request. The reset request clears itself when the frame ends.

Top module: `hk_cfg_spi`

## Requirements
- R1: After reset the four enables read 1. The configuration byte, PLL divider, PLL select, PLL trim, interrupt and reset request are 0, and the serial output is 0.
- R2: SPI mode 0, MSB first. A command byte of the form 10aaaaaa writes each following full byte to address a, then a+1, and so on. The 6-bit address wraps from 0x3F to 0x00.
- R3: A command byte of the form 01aaaaaa reads. Starting on the falling clock edge after the command's last bit, the output shifts out, MSB first, the bytes at a, a+1, and so on. Bytes arriving on the input during a read are ignored.
- R4: Register map. 0x00 is the configuration byte. 0x01 holds the enables: bit0 crystal, bit1 regulator, bit2 bandgap, bit3 PLL. 0x02 holds the PLL divider in bits 4:0 and the PLL select in bits 7:5. 0x03 to 0x06 hold the trim, least significant byte first, with only bits 1:0 used at 0x06. 0x0B holds the reset request in bit0 and the interrupt in bit1. Unused bits read 0.
- R5: The identifier registers are read-only and ignore writes. 0x07 holds manufacturer ID bits 7:0 and 0x08 holds bits 11:8. 0x09 holds the product ID and 0x0A the mask revision.
- R6: Reads of addresses 0x0C to 0x3F return 0x00.
- R7: A command byte of the form 11ssssss makes the serial output follow tap input s combinationally until chip select rises. For s at or above the tap count the output is 0.
- R8: Raising chip select ends the frame. A partial byte is discarded, and the next frame starts again with a command byte.
- R9: The reset request bit clears on the first core clock after chip select is seen high.
- R10: The interrupt output follows bit1 of 0x0B. It keeps its value across frame ends.
- R11: A command byte whose top two bits are 00 is ignored, along with the rest of its frame.
- R12: The serial output is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csb | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out |
| tap_in | input | NTAP | Internal signals for pass-through |
| cfg_byte | output | 8 | General configuration byte |
| xtal_en | output | 1 | Crystal oscillator enable |
| vreg_en | output | 1 | Core regulator enable |
| bgap_en | output | 1 | Bandgap enable |
| pll_en | output | 1 | PLL enable |
| pll_div | output | 5 | PLL divider |
| pll_sel | output | 3 | PLL select |
| pll_trim | output | 26 | PLL trim |
| mfr_id | output | 12 | Manufacturer identifier |
| prod_id | output | 8 | Product identifier |
| mask_rev | output | 4 | Mask revision |
| irq | output | 1 | Interrupt to the processor |
| ext_rst_req | output | 1 | Reset request ORed into processor reset |

## Verification
The assertions rely on the serial clock idling low and on each serial clock phase lasting at least four core clocks. The pins pass through two synchroniser flops and an edge-detect flop, so a shorter phase could merge edges or lose them. They also assume chip select stays high long enough to be seen before the next frame starts. The stimulus holds every serial clock phase for six core clocks and leaves twelve cycles between frames. It changes the data pin only while the serial clock is low. Pass-through taps are changed only while the serial clock is idle.

// File: rtl/hk_cfg_pkg.sv
// Shared constants for the housekeeping SPI configuration slave.
// Assumes: single core clock domain; all field widths fixed by the register map.
package hk_cfg_pkg;
    localparam int AW     = 6;
    localparam int BW     = 8;
    localparam int EN_W   = 4;
    localparam int DIV_W  = 5;
    localparam int SEL_W  = 3;
    localparam int TRIM_W = 26;

    localparam logic [EN_W-1:0] EN_RST = '1;

    localparam logic [AW-1:0] A_CFG    = 6'h00;
    localparam logic [AW-1:0] A_EN     = 6'h01;
    localparam logic [AW-1:0] A_PLL    = 6'h02;
    localparam logic [AW-1:0] A_TRIM0  = 6'h03;
    localparam logic [AW-1:0] A_TRIM1  = 6'h04;
    localparam logic [AW-1:0] A_TRIM2  = 6'h05;
    localparam logic [AW-1:0] A_TRIM3  = 6'h06;
    localparam logic [AW-1:0] A_MFR_LO = 6'h07;
    localparam logic [AW-1:0] A_MFR_HI = 6'h08;
    localparam logic [AW-1:0] A_PROD   = 6'h09;
    localparam logic [AW-1:0] A_REV    = 6'h0A;
    localparam logic [AW-1:0] A_CTL    = 6'h0B;

    typedef enum logic [2:0] {
        ST_CMD, ST_WR, ST_RD, ST_PASS, ST_SKIP
    } fstate_t;
endpackage

// File: rtl/hk_sync.sv
// Two-flop synchroniser for a bundle of independent asynchronous pins.
// Assumes: each bit is sampled independently; RST gives the idle level.
module hk_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture of the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST;
            q    <= RST;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hk_frame.sv
// SPI mode-0 frame engine running on synchronised pins in the core domain.
// Decodes the command byte, generates write strobes, shifts read data out
// and selects the pass-through tap.
// Assumes: sck idles low, each sck phase spans at least four core clocks.
module hk_frame
    import hk_cfg_pkg::*;
#(
    parameter int NTAP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csb_s,
    input  logic          sck_s,
    input  logic          sdi_s,
    input  logic [NTAP-1:0] tap_in,
    input  logic [BW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [BW-1:0] wr_data,
    output logic          frame_end,
    output logic          sdo
);
    fstate_t       st;
    logic [2:0]    cnt;
    logic [BW-2:0] shreg;
    logic [AW-1:0] addr;
    logic [AW-1:0] psel;
    logic [BW-1:0] txsh;
    logic          sck_d, csb_d;
    logic          rise, fall, last, pass_bit;
    logic [BW-1:0] byte_in;

    assign rise      = sck_s & ~sck_d & ~csb_s;
    assign fall      = ~sck_s & sck_d & ~csb_s;
    assign byte_in   = {shreg, sdi_s};
    assign last      = rise && (cnt == 3'd7);
    assign frame_end = csb_s & ~csb_d;
    assign rd_addr   = (st == ST_CMD) ? byte_in[AW-1:0] : addr;
    assign wr_en     = last && (st == ST_WR);
    assign wr_addr   = addr;
    assign wr_data   = byte_in;

    // Edge-detect history of the synchronised clock and select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            csb_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            csb_d <= csb_s;
        end
    end

    // Bit counting, command decode, address stepping and read shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_CMD;
            cnt   <= '0;
            shreg <= '0;
            addr  <= '0;
            psel  <= '0;
            txsh  <= '0;
        end else if (csb_s) begin
            st   <= ST_CMD;
            cnt  <= '0;
            txsh <= '0;
        end else begin
            if (rise) begin
                cnt   <= cnt + 3'd1;
                shreg <= byte_in[BW-2:0];
            end
            if (last) begin
                case (st)
                    ST_CMD: begin
                        case (byte_in[7:6])
                            2'b10: begin
                                st   <= ST_WR;
                                addr <= byte_in[AW-1:0];
                            end
                            2'b01: begin
                                st   <= ST_RD;
                                addr <= byte_in[AW-1:0] + 6'd1;
                                txsh <= rd_data;
                            end
                            2'b11: begin
                                st   <= ST_PASS;
                                psel <= byte_in[AW-1:0];
                            end
                            default: st <= ST_SKIP;
                        endcase
                    end
                    ST_WR: addr <= addr + 6'd1;
                    ST_RD: begin
                        addr <= addr + 6'd1;
                        txsh <= rd_data;
                    end
                    default: ;
                endcase
            end else if (fall && (cnt != 3'd0)) begin
                txsh <= {txsh[BW-2:0], 1'b0};
            end
        end
    end

    // Pick the pass-through tap; out-of-range selects give 0
    always_comb begin
        pass_bit = 1'b0;
        for (int i = 0; i < NTAP; i++) begin
            if (psel == AW'(i)) pass_bit = tap_in[i];
        end
    end

    // Serial output source: live tap in pass-through, else read shifter
    always_comb begin
        sdo = (st == ST_PASS) ? pass_bit : txsh[BW-1];
    end

    assert_sdo_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (csb_s && $past(csb_s)) |-> !sdo);

    assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !csb_s) |=> $stable(cnt));

    assert_end_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (cnt == 3'd0));
endmodule

// File: rtl/hk_regs.sv
// Configuration register file: holds writable fields, serves reads and
// clears the reset request at each frame end.
// Assumes: wr_en and frame_end never coincide.
module hk_regs
    import hk_cfg_pkg::*;
#(
    parameter logic [11:0] MFR_ID   = 12'h5A3,
    parameter logic [7:0]  PROD_ID  = 8'h42,
    parameter logic [3:0]  MASK_REV = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BW-1:0]     wr_data,
    input  logic              frame_end,
    input  logic [AW-1:0]     rd_addr,
    output logic [BW-1:0]     rd_data,
    output logic [BW-1:0]     cfg,
    output logic [EN_W-1:0]   en,
    output logic [DIV_W-1:0]  div,
    output logic [SEL_W-1:0]  sel,
    output logic [TRIM_W-1:0] trim,
    output logic              irq,
    output logic              rst_req
);
    // Register writes, reset defaults and reset-request self-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            en      <= EN_RST;
            div     <= '0;
            sel     <= '0;
            trim    <= '0;
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (frame_end) rst_req <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    A_CFG:   cfg          <= wr_data;
                    A_EN:    en           <= wr_data[EN_W-1:0];
                    A_PLL:   {sel, div}   <= wr_data;
                    A_TRIM0: trim[7:0]    <= wr_data;
                    A_TRIM1: trim[15:8]   <= wr_data;
                    A_TRIM2: trim[23:16]  <= wr_data;
                    A_TRIM3: trim[25:24]  <= wr_data[1:0];
                    A_CTL: begin
                        rst_req <= wr_data[0];
                        irq     <= wr_data[1];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer; unmapped addresses return zero
    always_comb begin
        case (rd_addr)
            A_CFG:    rd_data = cfg;
            A_EN:     rd_data = {4'b0, en};
            A_PLL:    rd_data = {sel, div};
            A_TRIM0:  rd_data = trim[7:0];
            A_TRIM1:  rd_data = trim[15:8];
            A_TRIM2:  rd_data = trim[23:16];
            A_TRIM3:  rd_data = {6'b0, trim[25:24]};
            A_MFR_LO: rd_data = MFR_ID[7:0];
            A_MFR_HI: rd_data = {4'b0, MFR_ID[11:8]};
            A_PROD:   rd_data = PROD_ID;
            A_REV:    rd_data = {4'b0, MASK_REV};
            A_CTL:    rd_data = {6'b0, irq, rst_req};
            default:  rd_data = '0;
        endcase
    end

    assert_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en == EN_RST && cfg == '0 && trim == '0 && !rst_req && !irq));

    assert_reqclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !rst_req);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({cfg, en, div, sel, trim, irq}));
endmodule

// File: rtl/hk_cfg_spi.sv
// Housekeeping SPI configuration slave top level: pin synchronisers,
// frame engine and register file.
// Assumes: csb/sck/sdi asynchronous to clk; outputs read-only to the processor.
module hk_cfg_spi
    import hk_cfg_pkg::*;
#(
    parameter logic [11:0] MFR_ID   = 12'h5A3,
    parameter logic [7:0]  PROD_ID  = 8'h42,
    parameter logic [3:0]  MASK_REV = 4'h1,
    parameter int          NTAP     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csb,
    input  logic              spi_sck,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    input  logic [NTAP-1:0]   tap_in,
    output logic [BW-1:0]     cfg_byte,
    output logic              xtal_en,
    output logic              vreg_en,
    output logic              bgap_en,
    output logic              pll_en,
    output logic [DIV_W-1:0]  pll_div,
    output logic [SEL_W-1:0]  pll_sel,
    output logic [TRIM_W-1:0] pll_trim,
    output logic [11:0]       mfr_id,
    output logic [7:0]        prod_id,
    output logic [3:0]        mask_rev,
    output logic              irq,
    output logic              ext_rst_req
);
    logic [2:0]      pins_s;
    logic [AW-1:0]   rd_addr, wr_addr;
    logic [BW-1:0]   rd_data, wr_data;
    logic            wr_en, frame_end;
    logic [EN_W-1:0] en;

    hk_sync #(.W(3), .RST(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_csb, spi_sck, spi_sdi}), .q(pins_s)
    );

    hk_frame #(.NTAP(NTAP)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .csb_s(pins_s[2]), .sck_s(pins_s[1]), .sdi_s(pins_s[0]),
        .tap_in(tap_in), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_end(frame_end), .sdo(spi_sdo)
    );

    hk_regs #(.MFR_ID(MFR_ID), .PROD_ID(PROD_ID), .MASK_REV(MASK_REV)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_end(frame_end), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg(cfg_byte), .en(en), .div(pll_div), .sel(pll_sel),
        .trim(pll_trim), .irq(irq), .rst_req(ext_rst_req)
    );

    assign xtal_en  = en[0];
    assign vreg_en  = en[1];
    assign bgap_en  = en[2];
    assign pll_en   = en[3];
    assign mfr_id   = MFR_ID;
    assign prod_id  = PROD_ID;
    assign mask_rev = MASK_REV;
endmodule

// File: tb/sim_hk_cfg_spi.sv
`timescale 1ns/1ps
module sim_hk_cfg_spi;
    localparam logic [11:0] MFR  = 12'h5A3;
    localparam logic [7:0]  PROD = 8'h42;
    localparam logic [3:0]  REV  = 4'h1;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csb = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic [3:0] tap = 4'h0;
    logic sdo, xtal_en, vreg_en, bgap_en, pll_en, irq, ext_rst_req;
    logic [7:0] cfg_byte, prod_id;
    logic [4:0] pll_div;
    logic [2:0] pll_sel;
    logic [25:0] pll_trim;
    logic [11:0] mfr_id;
    logic [3:0] mask_rev;

    int total = 0, bad = 0, cyc = 0;
    logic cmp_en = 1'b0;
    logic [7:0] m [64];
    logic [7:0] dq [$];
    logic [7:0] rx;

    always #2.5 clk = ~clk;

    hk_cfg_spi #(.MFR_ID(MFR), .PROD_ID(PROD), .MASK_REV(REV), .NTAP(4)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_csb(csb), .spi_sck(sck), .spi_sdi(sdi),
        .spi_sdo(sdo), .tap_in(tap), .cfg_byte(cfg_byte), .xtal_en(xtal_en),
        .vreg_en(vreg_en), .bgap_en(bgap_en), .pll_en(pll_en), .pll_div(pll_div),
        .pll_sel(pll_sel), .pll_trim(pll_trim), .mfr_id(mfr_id), .prod_id(prod_id),
        .mask_rev(mask_rev), .irq(irq), .ext_rst_req(ext_rst_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural register model (R4, R5 writable masks)
    function automatic void mwrite(input int a, input logic [7:0] d);
        case (a)
            0, 2, 3, 4, 5: m[a] = d;
            1:             m[a] = d & 8'h0F;
            6, 11:         m[a] = d & 8'h03;
            default: ;
        endcase
    endfunction

    task automatic cmp_all(input string tag);
        chk({tag, " cfg"}, cfg_byte, m[0]);
        chk({tag, " en"}, {pll_en, bgap_en, vreg_en, xtal_en}, m[1][3:0]);
        chk({tag, " pll"}, {pll_sel, pll_div}, m[2]);
        chk({tag, " trim"}, pll_trim, {m[6][1:0], m[5], m[4], m[3]});
        chk({tag, " ctl"}, {irq, ext_rst_req}, m[11][1:0]);
        chk({tag, " ids"}, {mfr_id, prod_id, mask_rev}, {m[8][3:0], m[7], m[9], m[10][3:0]});
    endtask

    // Every clock between frames the outputs must match the model (R4)
    always @(negedge clk) begin
        if (cmp_en) cmp_all("R4 idle");
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] r);
        r = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk); sdi = tx[i];
            repeat (HALF) @(negedge clk);
            r[i] = sdo; sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        cmp_en = 1'b0;
        @(negedge clk); csb = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high();
        @(negedge clk); csb = 1'b1;
        repeat (12) @(negedge clk);
        m[11][0] = 1'b0;
    endtask

    task automatic wr_frame(input int a, input logic [7:0] q [$]);
        logic [7:0] r;
        int ad;
        cs_low();
        spi_bits(8'h80 | 8'(a), 8, r);
        foreach (q[k]) spi_bits(q[k], 8, r);
        cs_high();
        ad = a;
        foreach (q[k]) begin
            mwrite(ad, q[k]);
            ad = (ad + 1) % 64;
        end
        cmp_en = 1'b1;
    endtask

    task automatic rd_check(input string tag, input int a, input int n);
        logic [7:0] r;
        int ad;
        cs_low();
        spi_bits(8'h40 | 8'(a), 8, r);
        ad = a;
        for (int k = 0; k < n; k++) begin
            spi_bits(8'h5A, 8, r);
            chk(tag, r, m[ad]);
            ad = (ad + 1) % 64;
        end
        cs_high();
        cmp_en = 1'b1;
    endtask

    initial begin
        foreach (m[i]) m[i] = 8'h00;
        m[1] = 8'h0F;
        m[7] = MFR[7:0];
        m[8] = {4'h0, MFR[11:8]};
        m[9] = PROD;
        m[10] = {4'h0, REV};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp_all("R1 reset");
        chk("R1 sdo reset", sdo, 1'b0);
        cmp_en = 1'b1;

        // R2/R4: burst write across the writable map
        dq = {8'hA5, 8'h05, 8'hB3, 8'h12, 8'h34, 8'h56, 8'hFF};
        wr_frame(0, dq);
        cmp_all("R2 burst write");
        chk("R4 pll_div", pll_div, 5'h13);
        chk("R4 pll_sel", pll_sel, 3'h5);
        chk("R4 trim", pll_trim, 26'h3563412);

        // R5: identifier writes ignored
        dq = {8'hFF, 8'hFF, 8'h00, 8'hEE};
        wr_frame(7, dq);
        cmp_all("R5 id write");

        // R3/R5: burst read of the whole map
        rd_check("R3 burst read", 0, 12);
        rd_check("R5 id read", 7, 4);
        // R6: unmapped reads
        rd_check("R6 unmapped", 6'h30, 3);
        // R2/R3: address wrap on read and on write
        rd_check("R3 wrap read", 6'h3F, 3);
        dq = {8'h11, 8'h22};
        wr_frame(6'h3F, dq);
        chk("R2 wrap write", cfg_byte, 8'h22);

        // R8: partial command and partial data byte discarded
        cs_low();
        spi_bits(8'h80, 4, rx);
        cs_high();
        cs_low();
        spi_bits(8'h80, 8, rx);
        spi_bits(8'hFF, 5, rx);
        cs_high();
        cmp_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 partial", cfg_byte, 8'h22);
        rd_check("R8 next frame", 0, 2);

        // R11: invalid command ignored with its frame
        cs_low();
        spi_bits(8'h00, 8, rx);
        spi_bits(8'h80, 8, rx);
        spi_bits(8'h55, 8, rx);
        chk("R11 sdo quiet", sdo, 1'b0);
        cs_high();
        cmp_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 no write", cfg_byte, 8'h22);

        // R7: pass-through of tap 2
        cs_low();
        spi_bits(8'hC2, 8, rx);
        repeat (4) @(negedge clk);
        tap = 4'b0100;
        @(negedge clk);
        chk("R7 tap2 high", sdo, 1'b1);
        tap = 4'b1011;
        @(negedge clk);
        chk("R7 tap2 low", sdo, 1'b0);
        tap = 4'b0100;
        @(negedge clk);
        chk("R7 tap2 high again", sdo, 1'b1);
        cs_high();
        // R12: output quiet after select rises
        chk("R12 sdo idle", sdo, 1'b0);
        // R7: out-of-range tap gives 0
        cs_low();
        spi_bits(8'hC5, 8, rx);
        tap = 4'hF;
        repeat (4) @(negedge clk);
        chk("R7 out of range", sdo, 1'b0);
        cs_high();
        tap = 4'h0;
        cmp_en = 1'b1;

        // R9/R10: reset request pulse and interrupt level
        cs_low();
        spi_bits(8'h8B, 8, rx);
        spi_bits(8'h03, 8, rx);
        repeat (10) @(negedge clk);
        chk("R9 req set", ext_rst_req, 1'b1);
        chk("R10 irq set", irq, 1'b1);
        cs_high();
        m[11] = 8'h02;
        chk("R9 req cleared", ext_rst_req, 1'b0);
        chk("R10 irq kept", irq, 1'b1);
        cmp_en = 1'b1;
        dq = {8'h00};
        wr_frame(11, dq);
        chk("R10 irq cleared", irq, 1'b0);
        rd_check("R3 final read", 0, 12);

        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule